// File: doc/BRIEF.md
# Rename Register Pool with In-Order Retirement

This block manages a small shared pool of physical rename registers that stand in for the architectural register file of an out-of-order integer core. When an operation that writes a register issues, the block takes a free rename register from the pool. It records that register as the newest speculative mapping of the destination architectural register, and it appends the operation to a program-order tracker. Execution units later report completion against the rename register tag, together with the result and an exception flag. Completions may arrive in any order.

A retirement stage looks at the oldest tracked operations and retires them strictly in program order, up to two per cycle. Retirement starts only when the oldest operation has completed. Only at retirement is the result copied into the architectural register file and the rename register returned to the pool. An exception is reported only when the faulting operation becomes the oldest, so exceptions appear in program order. A flush discards every unretired operation in a single cycle. All rename registers go back to the pool, and every speculative mapping is dropped, so reads see the committed state again.

Top module: `rename_pool`

## Requirements
- R1: After reset, all 14 rename registers are free, `alloc_ready_o` is 1 with `alloc_tag_o` = 0, no architectural register is mapped, every committed value reads as 0, and nothing retires.
- R2: An allocate request with `alloc_ready_o` high is granted in that cycle and receives the lowest-numbered free rename register (tags 0 to 13) on `alloc_tag_o`.
- R3: When no rename register is free, `alloc_ready_o` is 0 and an allocate request is refused without changing any state. `alloc_ready_o` is also 0 during a flush cycle.
- R4: `rd_mapped_o` is 1 exactly when the architectural register on `rd_arch_i` has a speculative mapping. `rd_tag_o` then gives the tag of the newest allocation to that register, visible from the cycle after the grant.
- R5: A completion marks its tag done. Completions may come in any order. Slot 0 (`ret_valid_o[0]`, `ret_arch_o[2:0]`, `ret_tag_o[3:0]`) retires the oldest operation in the cycle after it is both oldest and done.
- R6: Slot 1 (`ret_valid_o[1]`, `ret_arch_o[5:3]`, `ret_tag_o[7:4]`) retires the second-oldest operation in the same cycle, but only when slot 0 retires normally and that operation is done without an exception. At most two operations retire per cycle.
- R7: A normal retirement writes the completion data into the committed architectural register, which `rd_data_o` shows from the next cycle. It returns the tag to the pool. It clears the mapping only if that mapping still names the retired tag.
- R8: An operation that completed with its exception flag set is reported only when it is the oldest: `exc_valid_o` is 1, `exc_arch_o` gives its destination, and `ret_valid_o` is 0. It frees its tag without writing the architectural register.
- R9: A flush frees every unretired rename register, drops all mappings and ignores completions in the same cycle, with no retirement in that cycle. From the next cycle, allocation restarts at tag 0 and committed values are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all unretired operations |
| alloc_valid_i | input | 1 | Allocate request for an issuing operation |
| alloc_arch_i | input | 3 | Destination architectural register |
| alloc_ready_o | output | 1 | Request is granted this cycle |
| alloc_tag_o | output | 4 | Rename register given to the request |
| cmpl_valid_i | input | 1 | Completion report |
| cmpl_tag_i | input | 4 | Tag of the completing operation |
| cmpl_data_i | input | 32 | Result value |
| cmpl_exc_i | input | 1 | Operation faulted |
| ret_valid_o | output | 2 | Per-slot normal retirement |
| ret_arch_o | output | 6 | Per-slot destination register, slot 0 in bits 2:0 |
| ret_tag_o | output | 8 | Per-slot retired tag, slot 0 in bits 3:0 |
| exc_valid_o | output | 1 | Oldest operation retires with an exception |
| exc_arch_o | output | 3 | Destination of the faulting operation |
| rd_arch_i | input | 3 | Architectural register to look up |
| rd_mapped_o | output | 1 | A speculative mapping exists |
| rd_tag_o | output | 4 | Newest rename register for that register |
| rd_data_o | output | 32 | Committed architectural value |

## Verification
The assertions assume that a completion only names a tag that is currently allocated and not yet completed, and that each tag completes at most once per allocation. They also assume that inputs are held at 0 while reset is active. The bench keeps within these limits by drawing completion tags from its own model's list of in-flight, not-yet-done operations. It mixes directed sequences with random issue, completion, rare exceptions and occasional flushes. The directed sequences cover a full pool, out-of-order completion, paired retirement, an exception that holds back a completed younger operation, and a flush.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned PHYS_REGS = 14;
  localparam int unsigned ARCH_REGS = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned RET_WIDTH = 2;
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int unsigned N = 14,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          take_i,
  input  logic [N-1:0]  give_i,
  output logic          avail_o,
  output logic [IW-1:0] pick_o
);
  logic [N-1:0] free_q;
  logic [N-1:0] take_mask;

  // lowest free index wins
  always_comb begin
    pick_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_q[i]) pick_o = IW'(i);
    end
  end

  assign avail_o   = |free_q;
  assign take_mask = take_i ? (N'(1) << pick_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      free_q <= '1;
    else if (flush_i) free_q <= '1;
    else              free_q <= (free_q | give_i) & ~take_mask;
  end
endmodule

// File: rtl/rn_order_q.sv
module rn_order_q #(
  parameter int unsigned DEPTH = 14,
  parameter int unsigned AW    = 3,
  parameter int unsigned TW    = 4,
  parameter int unsigned RN    = 2,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_arch_i,
  input  logic [TW-1:0] push_tag_i,
  input  logic [CW-1:0] pop_i,
  output logic [RN-1:0] slot_vld_o,
  output logic [AW-1:0] slot_arch_o [RN],
  output logic [TW-1:0] slot_tag_o  [RN]
);
  logic [AW-1:0] arch_q [DEPTH];
  logic [TW-1:0] tag_q  [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] wrap(input logic [PW:0] v);
    return (v >= (PW+1)'(DEPTH)) ? PW'(v - (PW+1)'(DEPTH)) : PW'(v);
  endfunction

  for (genvar i = 0; i < RN; i++) begin : g_slot
    logic [PW-1:0] idx;
    assign idx            = wrap({1'b0, head_q} + (PW+1)'(i));
    assign slot_vld_o[i]  = cnt_q > CW'(i);
    assign slot_arch_o[i] = arch_q[idx];
    assign slot_tag_o[i]  = tag_q[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        arch_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) begin
        arch_q[tail_q] <= push_arch_i;
        tag_q[tail_q]  <= push_tag_i;
        tail_q         <= wrap({1'b0, tail_q} + (PW+1)'(1));
      end
      head_q <= wrap({1'b0, head_q} + (PW+1)'(pop_i));
      cnt_q  <= cnt_q + CW'(push_i) - pop_i;
    end
  end
endmodule

// File: rtl/rn_spec_map.sv
module rn_spec_map #(
  parameter int unsigned NA = 8,
  parameter int unsigned TW = 4,
  parameter int unsigned RN = 2,
  localparam int unsigned AW = $clog2(NA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          set_i,
  input  logic [AW-1:0] set_arch_i,
  input  logic [TW-1:0] set_tag_i,
  input  logic [RN-1:0] clr_i,
  input  logic [AW-1:0] clr_arch_i [RN],
  input  logic [TW-1:0] clr_tag_i  [RN],
  input  logic [AW-1:0] rd_arch_i,
  output logic          rd_mapped_o,
  output logic [TW-1:0] rd_tag_o
);
  logic [NA-1:0] vld_q;
  logic [TW-1:0] tag_q [NA];

  assign rd_mapped_o = vld_q[rd_arch_i];
  assign rd_tag_o    = tag_q[rd_arch_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < NA; i++) tag_q[i] <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else begin
      // drop a mapping only if it still names the retiring tag
      for (int i = 0; i < RN; i++) begin
        if (clr_i[i] && vld_q[clr_arch_i[i]] && tag_q[clr_arch_i[i]] == clr_tag_i[i])
          vld_q[clr_arch_i[i]] <= 1'b0;
      end
      // a new allocation overrides any clear above
      if (set_i) begin
        vld_q[set_arch_i] <= 1'b1;
        tag_q[set_arch_i] <= set_tag_i;
      end
    end
  end
endmodule

// File: rtl/rn_regs.sv
module rn_regs #(
  parameter int unsigned NP = 14,
  parameter int unsigned NA = 8,
  parameter int unsigned DW = 32,
  parameter int unsigned RN = 2,
  localparam int unsigned TW = $clog2(NP),
  localparam int unsigned AW = $clog2(NA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pw_en_i,
  input  logic [TW-1:0] pw_tag_i,
  input  logic [DW-1:0] pw_data_i,
  input  logic [RN-1:0] cm_en_i,
  input  logic [AW-1:0] cm_arch_i [RN],
  input  logic [TW-1:0] cm_tag_i  [RN],
  input  logic [AW-1:0] rd_arch_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] phys_q [NP];
  logic [DW-1:0] arch_q [NA];

  assign rd_data_o = arch_q[rd_arch_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NP; i++) phys_q[i] <= '0;
    end else if (pw_en_i) begin
      phys_q[pw_tag_i] <= pw_data_i;
    end
  end

  // younger slot written last so it wins on a shared destination
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NA; i++) arch_q[i] <= '0;
    end else begin
      for (int i = 0; i < RN; i++) begin
        if (cm_en_i[i]) arch_q[cm_arch_i[i]] <= phys_q[cm_tag_i[i]];
      end
    end
  end
endmodule

// File: rtl/rename_pool.sv
module rename_pool #(
  parameter int unsigned NUM_PHYS = rn_pkg::PHYS_REGS,
  parameter int unsigned NUM_ARCH = rn_pkg::ARCH_REGS,
  parameter int unsigned DATA_W   = rn_pkg::WORD_W,
  parameter int unsigned RET_N    = rn_pkg::RET_WIDTH,
  localparam int unsigned TAG_W  = $clog2(NUM_PHYS),
  localparam int unsigned ARCH_W = $clog2(NUM_ARCH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    alloc_valid_i,
  input  logic [ARCH_W-1:0]       alloc_arch_i,
  output logic                    alloc_ready_o,
  output logic [TAG_W-1:0]        alloc_tag_o,
  input  logic                    cmpl_valid_i,
  input  logic [TAG_W-1:0]        cmpl_tag_i,
  input  logic [DATA_W-1:0]       cmpl_data_i,
  input  logic                    cmpl_exc_i,
  output logic [RET_N-1:0]        ret_valid_o,
  output logic [RET_N*ARCH_W-1:0] ret_arch_o,
  output logic [RET_N*TAG_W-1:0]  ret_tag_o,
  output logic                    exc_valid_o,
  output logic [ARCH_W-1:0]       exc_arch_o,
  input  logic [ARCH_W-1:0]       rd_arch_i,
  output logic                    rd_mapped_o,
  output logic [TAG_W-1:0]        rd_tag_o,
  output logic [DATA_W-1:0]       rd_data_o
);
  localparam int unsigned CNT_W = $clog2(NUM_PHYS + 1);

  logic                avail, take, cmpl_en;
  logic [NUM_PHYS-1:0] done_q, exc_q, give_mask;
  logic [RET_N-1:0]    slot_vld, go, wr;
  logic [ARCH_W-1:0]   slot_arch [RET_N];
  logic [TAG_W-1:0]    slot_tag  [RET_N];
  logic [CNT_W-1:0]    pop_cnt;

  assign alloc_ready_o = avail && !flush_i;
  assign take          = alloc_valid_i && alloc_ready_o;
  assign cmpl_en       = cmpl_valid_i && !flush_i;

  // slot i retires only behind a normal retirement in slot i-1
  always_comb begin
    go = '0;
    wr = '0;
    for (int i = 0; i < RET_N; i++) begin
      if (i == 0)
        go[i] = !flush_i && slot_vld[i] && done_q[slot_tag[i]];
      else
        go[i] = wr[i-1] && slot_vld[i] && done_q[slot_tag[i]] && !exc_q[slot_tag[i]];
      wr[i] = go[i] && !exc_q[slot_tag[i]];
    end
  end

  always_comb begin
    pop_cnt   = '0;
    give_mask = '0;
    for (int i = 0; i < RET_N; i++) begin
      pop_cnt = pop_cnt + CNT_W'(go[i]);
      if (go[i]) give_mask[slot_tag[i]] = 1'b1;
    end
  end

  assign ret_valid_o = wr;
  assign exc_valid_o = go[0] && exc_q[slot_tag[0]];
  assign exc_arch_o  = slot_arch[0];

  for (genvar i = 0; i < RET_N; i++) begin : g_ret
    assign ret_arch_o[i*ARCH_W +: ARCH_W] = slot_arch[i];
    assign ret_tag_o[i*TAG_W +: TAG_W]    = slot_tag[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      exc_q  <= '0;
    end else if (flush_i) begin
      done_q <= '0;
    end else begin
      for (int i = 0; i < RET_N; i++) begin
        if (go[i]) done_q[slot_tag[i]] <= 1'b0;
      end
      if (cmpl_en) begin
        done_q[cmpl_tag_i] <= 1'b1;
        exc_q[cmpl_tag_i]  <= cmpl_exc_i;
      end
    end
  end

  rn_free_pool #(.N(NUM_PHYS)) u_pool (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .take_i  (take),
    .give_i  (give_mask),
    .avail_o (avail),
    .pick_o  (alloc_tag_o)
  );

  rn_order_q #(.DEPTH(NUM_PHYS), .AW(ARCH_W), .TW(TAG_W), .RN(RET_N)) u_order (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (take),
    .push_arch_i (alloc_arch_i),
    .push_tag_i  (alloc_tag_o),
    .pop_i       (pop_cnt),
    .slot_vld_o  (slot_vld),
    .slot_arch_o (slot_arch),
    .slot_tag_o  (slot_tag)
  );

  rn_spec_map #(.NA(NUM_ARCH), .TW(TAG_W), .RN(RET_N)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .set_i       (take),
    .set_arch_i  (alloc_arch_i),
    .set_tag_i   (alloc_tag_o),
    .clr_i       (go),
    .clr_arch_i  (slot_arch),
    .clr_tag_i   (slot_tag),
    .rd_arch_i   (rd_arch_i),
    .rd_mapped_o (rd_mapped_o),
    .rd_tag_o    (rd_tag_o)
  );

  rn_regs #(.NP(NUM_PHYS), .NA(NUM_ARCH), .DW(DATA_W), .RN(RET_N)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pw_en_i   (cmpl_en),
    .pw_tag_i  (cmpl_tag_i),
    .pw_data_i (cmpl_data_i),
    .cm_en_i   (wr),
    .cm_arch_i (slot_arch),
    .cm_tag_i  (slot_tag),
    .rd_arch_i (rd_arch_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/rename_pool_chk.sv
module rename_pool_chk #(
  parameter int unsigned NUM_PHYS = 14,
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned RET_N    = 2,
  localparam int unsigned TAG_W  = $clog2(NUM_PHYS),
  localparam int unsigned ARCH_W = $clog2(NUM_ARCH)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    flush_i,
  input logic                    alloc_valid_i,
  input logic [ARCH_W-1:0]       alloc_arch_i,
  input logic                    alloc_ready_o,
  input logic [TAG_W-1:0]        alloc_tag_o,
  input logic [RET_N-1:0]        ret_valid_o,
  input logic [RET_N*TAG_W-1:0]  ret_tag_o,
  input logic                    exc_valid_o,
  input logic [ARCH_W-1:0]       rd_arch_i,
  input logic                    rd_mapped_o,
  input logic [TAG_W-1:0]        rd_tag_o
);
  AST_TAG_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ready_o |-> alloc_tag_o < TAG_W'(NUM_PHYS)); // R2

  AST_FULL_STAYS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_ready_o && !flush_i && ret_valid_o == '0 && !exc_valid_o) |=> !alloc_ready_o); // R3

  AST_ALLOC_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(alloc_valid_i && alloc_ready_o) && rd_arch_i == $past(alloc_arch_i))
      |-> (rd_mapped_o && rd_tag_o == $past(alloc_tag_o))); // R4

  AST_EXC_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> ret_valid_o == '0); // R8

  AST_FLUSH_UNMAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !rd_mapped_o); // R9

  AST_FLUSH_REFILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> alloc_tag_o == '0); // R9

  for (genvar i = 1; i < RET_N; i++) begin : g_pair
    AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_valid_o[i] |-> ret_valid_o[i-1]); // R6

    AST_TAGS_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_valid_o[i] |-> ret_tag_o[i*TAG_W +: TAG_W] != ret_tag_o[(i-1)*TAG_W +: TAG_W]); // R6
  end
endmodule

bind rename_pool rename_pool_chk #(
  .NUM_PHYS (NUM_PHYS),
  .NUM_ARCH (NUM_ARCH),
  .RET_N    (RET_N)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .alloc_valid_i (alloc_valid_i),
  .alloc_arch_i  (alloc_arch_i),
  .alloc_ready_o (alloc_ready_o),
  .alloc_tag_o   (alloc_tag_o),
  .ret_valid_o   (ret_valid_o),
  .ret_tag_o     (ret_tag_o),
  .exc_valid_o   (exc_valid_o),
  .rd_arch_i     (rd_arch_i),
  .rd_mapped_o   (rd_mapped_o),
  .rd_tag_o      (rd_tag_o)
);

// File: tb/tb_rename_pool.sv
module tb_rename_pool;
  localparam int NP = 14;
  localparam int NA = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [2:0]  alloc_arch_i = '0;
  logic        alloc_ready_o;
  logic [3:0]  alloc_tag_o;
  logic        cmpl_valid_i = 1'b0;
  logic [3:0]  cmpl_tag_i = '0;
  logic [31:0] cmpl_data_i = '0;
  logic        cmpl_exc_i = 1'b0;
  logic [1:0]  ret_valid_o;
  logic [5:0]  ret_arch_o;
  logic [7:0]  ret_tag_o;
  logic        exc_valid_o;
  logic [2:0]  exc_arch_o;
  logic [2:0]  rd_arch_i = '0;
  logic        rd_mapped_o;
  logic [3:0]  rd_tag_o;
  logic [31:0] rd_data_o;

  always #10 clk_i = ~clk_i;

  rename_pool dut (.*);

  int total = 0;
  int bad = 0;

  // reference model state
  bit          m_free [NP];
  int          q_tag  [NP];
  int          q_arch [NP];
  int          m_head, m_cnt;
  bit          m_done [NP];
  bit          m_exc  [NP];
  logic [31:0] m_pdata [NP];
  logic [31:0] m_adata [NA];
  bit          m_mv [NA];
  int          m_mt [NA];
  bit          last_exc;

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit av, int aa, bit cv, int ct, logic [31:0] cd, bit ce, bit fl, int ra);
    int pick, t0, t1, a0, a1;
    bit rdy, g0, g1, e0;
    alloc_valid_i = av; alloc_arch_i = 3'(aa);
    cmpl_valid_i = cv; cmpl_tag_i = 4'(ct); cmpl_data_i = cd; cmpl_exc_i = ce;
    flush_i = fl; rd_arch_i = 3'(ra);
    #2;
    pick = -1;
    for (int i = 0; i < NP; i++) if (m_free[i] && pick < 0) pick = i;
    rdy = (pick >= 0) && !fl;
    check(fl ? "R9" : "R3", "alloc_ready", alloc_ready_o, rdy);
    if (rdy) check("R2", "alloc_tag", alloc_tag_o, pick);
    t0 = q_tag[m_head];           a0 = q_arch[m_head];
    t1 = q_tag[(m_head + 1) % NP]; a1 = q_arch[(m_head + 1) % NP];
    g0 = !fl && m_cnt >= 1 && m_done[t0];
    e0 = g0 && m_exc[t0];
    g1 = g0 && !e0 && m_cnt >= 2 && m_done[t1] && !m_exc[t1];
    check(fl ? "R9" : "R5", "ret_valid0", ret_valid_o[0], g0 && !e0);
    check("R6", "ret_valid1", ret_valid_o[1], g1);
    check("R8", "exc_valid", exc_valid_o, e0);
    if (e0) check("R8", "exc_arch", exc_arch_o, a0);
    if (g0 && !e0) begin
      check("R5", "ret_arch0", ret_arch_o[2:0], a0);
      check("R5", "ret_tag0", ret_tag_o[3:0], t0);
    end
    if (g1) begin
      check("R6", "ret_arch1", ret_arch_o[5:3], a1);
      check("R6", "ret_tag1", ret_tag_o[7:4], t1);
    end
    check("R4", "rd_mapped", rd_mapped_o, m_mv[ra]);
    if (m_mv[ra]) check("R4", "rd_tag", rd_tag_o, m_mt[ra]);
    check("R7", "rd_data", rd_data_o, m_adata[ra]);
    last_exc = e0;
    // next state
    if (fl) begin
      for (int i = 0; i < NP; i++) begin m_free[i] = 1; m_done[i] = 0; end
      for (int i = 0; i < NA; i++) m_mv[i] = 0;
      m_cnt = 0; m_head = 0;
    end else begin
      if (g0) begin
        if (!e0) m_adata[a0] = m_pdata[t0];
        if (m_mv[a0] && m_mt[a0] == t0) m_mv[a0] = 0;
        m_free[t0] = 1; m_done[t0] = 0;
      end
      if (g1) begin
        m_adata[a1] = m_pdata[t1];
        if (m_mv[a1] && m_mt[a1] == t1) m_mv[a1] = 0;
        m_free[t1] = 1; m_done[t1] = 0;
      end
      m_head = (m_head + int'(g0) + int'(g1)) % NP;
      m_cnt  = m_cnt - int'(g0) - int'(g1);
      if (cv) begin m_done[ct] = 1; m_exc[ct] = ce; m_pdata[ct] = cd; end
      if (av && rdy) begin
        m_free[pick] = 0;
        q_tag[(m_head + m_cnt) % NP] = pick;
        q_arch[(m_head + m_cnt) % NP] = aa;
        m_cnt++;
        m_mv[aa] = 1; m_mt[aa] = pick;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(int ra);
    step(0, 0, 0, 0, '0, 0, 0, ra);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit pend_flush;
    void'($urandom(32'd7351));
    for (int i = 0; i < NP; i++) begin
      m_free[i] = 1; m_done[i] = 0; m_exc[i] = 0; m_pdata[i] = '0; q_tag[i] = 0; q_arch[i] = 0;
    end
    for (int i = 0; i < NA; i++) begin m_adata[i] = '0; m_mv[i] = 0; m_mt[i] = 0; end
    m_head = 0; m_cnt = 0; pend_flush = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    // R1 reset state
    check("R1", "alloc_ready", alloc_ready_o, 1);
    check("R1", "alloc_tag", alloc_tag_o, 0);
    check("R1", "rd_mapped", rd_mapped_o, 0);
    check("R1", "rd_data", rd_data_o, 0);
    check("R1", "ret_valid", ret_valid_o, 0);
    check("R1", "exc_valid", exc_valid_o, 0);
    @(negedge clk_i);

    // R2/R3: fill all 14, then a refused request
    for (int i = 0; i < NP; i++) step(1, i % NA, 0, 0, '0, 0, 0, (i + 7) % NA);
    step(1, 2, 0, 0, '0, 0, 0, 3);
    idle(3);
    // R5: out-of-order completion, head not done yet
    step(0, 0, 1, 5, 32'h55, 0, 0, 5);
    idle(0);
    step(0, 0, 1, 0, 32'hA0, 0, 0, 0);
    idle(0);
    // R6: two done together retire as a pair
    step(0, 0, 1, 1, 32'hB1, 0, 0, 1);
    step(0, 0, 1, 2, 32'hC2, 0, 0, 1);
    step(0, 0, 1, 3, 32'hD3, 0, 0, 2);
    step(0, 0, 1, 4, 32'hE4, 0, 0, 3);
    repeat (4) idle(4);
    step(1, 6, 0, 0, '0, 0, 0, 6);
    // R8: younger done, oldest faults
    step(0, 0, 1, 7, 32'h77, 0, 0, 7);
    step(0, 0, 1, 6, 32'h66, 1, 0, 6);
    idle(6);
    idle(7);
    // R9: flush with a completion in the same cycle
    step(1, 1, 1, 8, 32'h88, 0, 1, 0);
    step(1, 1, 0, 0, '0, 0, 0, 1);
    idle(1);

    for (int n = 0; n < 4000; n++) begin
      bit av, cv, ce, fl;
      int ct;
      av = $urandom_range(99) < 55;
      cv = 0; ct = 0;
      if (m_cnt > 0 && $urandom_range(99) < 60) begin
        int t;
        t = q_tag[(m_head + $urandom_range(m_cnt - 1)) % NP];
        if (!m_done[t]) begin cv = 1; ct = t; end
      end
      ce = cv && ($urandom_range(99) < 4);
      fl = pend_flush || ($urandom_range(99) < 2);
      step(av, $urandom_range(NA - 1), cv, ct, $urandom, ce, fl, $urandom_range(NA - 1));
      pend_flush = last_exc && ($urandom_range(1) == 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule